// File: doc/BRIEF.md
# Slave FIFO Streaming Write Controller

This block sits on the FPGA side of a synchronous slave FIFO link to an external USB bridge and acts as the bus master. It pushes a steady sample stream into the bridge, one 32-bit word per interface clock. Samples are first staged in a local buffer FIFO. From there the controller writes them to the buffer thread picked by a 2-bit address.

A burst opens only after the bridge's ready flag for that thread has been seen high for a qualifying number of consecutive cycles. A ready pulse that is too short to qualify, such as the one that can follow a completely filled buffer, starts nothing. The burst closes on the active-low watermark flag rather than on ready. Ready reports a full buffer late, while the watermark gives several words of warning, so it covers the flag latency.

In block mode, every 1026-word (4104-byte) block ends with a packet-end strobe on its final word. In continuous mode, words flow with no packet ends until acquisition stops. Samples that arrive while the local FIFO is full are discarded, and a saturating counter records each one.

Top module: `sfifo_stream_writer`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `bus_wr` and `bus_pkt_end` are 0, and `bus_addr` and `drop_count` are 0.
- R2: A burst starts only after `flag_ready` has been high for RDY_QUAL (default 2) consecutive cycles after its SYNC_STAGES-deep synchronizer. A one-cycle ready pulse causes no write.
- R3: Each cycle with `bus_wr` high presents exactly one sample on `bus_data`. Samples leave in the order they were accepted, with none repeated or skipped. While ready, watermark and `run` permit, the buffer drains at one word per cycle.
- R4: After `flag_wm_n` goes low, at most SYNC_STAGES (2) more words are written, which stays within the WM_WORDS (4) budget. No word is written once it has been low for longer than that. Writing resumes once `flag_wm_n` is high again and ready is qualified.
- R5: With `mode_block`=1, `bus_pkt_end` is high together with `bus_wr` on the last word of every BLOCK_WORDS (1026) word block, and it is low on all other words.
- R6: With `mode_block`=0, `bus_pkt_end` is never high.
- R7: `bus_addr` takes the value of `thread_sel` when a burst starts. A change of `thread_sel` during a burst has no effect on `bus_addr` until a later burst starts.
- R8: The local buffer holds FIFO_DEPTH (16) samples. A sample offered while it is full is discarded, and `drop_count` rises by one for that sample. Samples already held are kept.
- R9: `drop_count` saturates at all ones (15 for CNT_W=4). A synchronous `rst` clears it to 0.
- R10: While `run` is low, `bus_wr` is low in that same cycle. The block word count restarts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Acquisition enable |
| mode_block | input | 1 | 1: per-block packets with packet end; 0: continuous stream |
| thread_sel | input | ADDR_W | Target thread, captured at burst start |
| smp_valid | input | 1 | Incoming sample strobe |
| smp_data | input | DATA_W | Incoming sample |
| flag_ready | input | 1 | Thread ready flag from the bridge, active high |
| flag_wm_n | input | 1 | Watermark flag from the bridge, active low |
| bus_data | output | DATA_W | Word driven to the bridge |
| bus_wr | output | 1 | Write strobe, active high |
| bus_pkt_end | output | 1 | Packet-end strobe, active high |
| bus_addr | output | ADDR_W | Thread address |
| drop_count | output | CNT_W | Saturating count of discarded samples |

## Verification
The bench fills the buffer with ready held low and overflows it past saturation. A counter that wrapped, or a buffer that overwrote held samples, would show up as a wrong count or as out-of-order words when the buffer is later drained. It applies a lone one-cycle ready pulse, which a design lacking qualification would answer with a burst. It drops the watermark in the middle of a stream and counts the trailing writes, which a design that stopped on ready would let run past the budget. Two full blocks check where packet ends land, against an off-by-one block length. A mid-burst thread change checks that the address was latched and not passed straight through.

// File: rtl/sfw_pkg.sv
package sfw_pkg;

   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_WRITE = 1'b1
   } wr_state_t;

endpackage

// File: rtl/sfw_sync.sv
module sfw_sync #(
   parameter int             W       = 2,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("sfw_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk) begin
      if (rst) begin
         stg <= {STAGES{RST_VAL}};
      end else begin
         stg[0] <= din;
         for (int i = 1; i < STAGES; i++) begin
            stg[i] <= stg[i-1];
         end
      end
   end

   assign dout = stg[STAGES-1];

endmodule

// File: rtl/sfw_fifo.sv
module sfw_fifo #(
   parameter int DW    = 32,
   parameter int DEPTH = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_valid,
   input  logic [DW-1:0] in_data,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic          empty,
   output logic          drop
);

   localparam int AW = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("sfw_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp;
   logic [AW-1:0] rp;
   logic [AW:0]   cnt;
   logic          full;
   logic          push;

   assign full  = (cnt == (AW+1)'(DEPTH));
   assign empty = (cnt == '0);
   assign push  = in_valid && !full;
   assign drop  = in_valid && full;
   assign head  = mem[rp];

   always_ff @(posedge clk) begin
      if (rst) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= wp + 1'b1;
         if (pop)  rp <= rp + 1'b1;
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= in_data;
   end

   // R8: occupancy never passes the buffer depth
   a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rst)
      cnt <= (AW+1)'(DEPTH));

   // R3: the controller never pulls from an empty buffer
   a_r3_no_underflow: assert property (@(posedge clk) disable iff (rst)
      pop |-> !empty);

endmodule

// File: rtl/sfw_drop_cnt.sv
module sfw_drop_cnt #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         hit,
   output logic [W-1:0] count
);

   generate
      if (W < 1) begin : g_bad_width
         $error("sfw_drop_cnt: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         count <= '0;
      end else if (hit && (count != {W{1'b1}})) begin
         count <= count + 1'b1;
      end
   end

   // R9: once saturated the count holds until reset
   a_r9_sat_hold: assert property (@(posedge clk) disable iff (rst)
      (count == {W{1'b1}}) |=> (count == {W{1'b1}}));

   // R8: the count moves by at most one per cycle
   a_r8_single_step: assert property (@(posedge clk) disable iff (rst)
      (count != $past(count)) |-> (count == $past(count) + 1'b1));

endmodule

// File: rtl/sfw_ctrl.sv
module sfw_ctrl
   import sfw_pkg::*;
#(
   parameter int BLOCK_WORDS = 1026,
   parameter int RDY_QUAL    = 2,
   parameter int ADDR_W      = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              run,
   input  logic              mode_block,
   input  logic [ADDR_W-1:0] thread_sel,
   input  logic              rdy_s,
   input  logic              wm_n_s,
   input  logic              fifo_empty,
   output logic              wr_strobe,
   output logic              pkt_end,
   output logic [ADDR_W-1:0] bus_addr
);

   localparam int BW = $clog2(BLOCK_WORDS);
   localparam logic [BW-1:0] LAST_WORD = BW'(BLOCK_WORDS - 1);

   generate
      if (BLOCK_WORDS < 2) begin : g_bad_block
         $error("sfw_ctrl: BLOCK_WORDS must be at least 2");
      end
      if (RDY_QUAL < 1) begin : g_bad_qual
         $error("sfw_ctrl: RDY_QUAL must be at least 1");
      end
   endgenerate

   // ready qualification: a flag must hold for RDY_QUAL cycles
   logic rdy_ok;

   generate
      if (RDY_QUAL > 1) begin : g_qual_cnt
         localparam int QW = $clog2(RDY_QUAL + 1);
         logic [QW-1:0] rdy_cnt;
         always_ff @(posedge clk) begin
            if (rst || !rdy_s) begin
               rdy_cnt <= '0;
            end else if (rdy_cnt != QW'(RDY_QUAL)) begin
               rdy_cnt <= rdy_cnt + 1'b1;
            end
         end
         assign rdy_ok = (rdy_cnt == QW'(RDY_QUAL));
      end else begin : g_qual_direct
         assign rdy_ok = rdy_s;
      end
   endgenerate

   wr_state_t state;
   logic      in_write;
   logic      start;
   logic [BW-1:0] wcnt;

   assign in_write  = (state == ST_WRITE);
   assign start     = !in_write && run && rdy_ok && wm_n_s && !fifo_empty;
   assign wr_strobe = in_write && run && wm_n_s && !fifo_empty;
   assign pkt_end   = wr_strobe && mode_block && (wcnt == LAST_WORD);

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_IDLE;
         bus_addr <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state    <= ST_WRITE;
                  bus_addr <= thread_sel;
               end
            end
            default: begin
               if (!run || !wm_n_s) state <= ST_IDLE;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst || !run || !mode_block) begin
         wcnt <= '0;
      end else if (wr_strobe) begin
         wcnt <= (wcnt == LAST_WORD) ? '0 : wcnt + 1'b1;
      end
   end

   // R2: every burst begins from a qualified ready flag
   a_r2_start_qualified: assert property (@(posedge clk) disable iff (rst)
      $rose(in_write) |-> $past(rdy_ok));

   // R7: the thread address is held for the whole burst
   a_r7_addr_hold: assert property (@(posedge clk) disable iff (rst)
      (in_write && $past(in_write)) |-> $stable(bus_addr));

   // R5: the block word index stays inside one block
   a_r5_block_range: assert property (@(posedge clk) disable iff (rst)
      wcnt <= LAST_WORD);

endmodule

// File: rtl/sfifo_stream_writer.sv
module sfifo_stream_writer #(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 2,
   parameter int FIFO_DEPTH  = 16,
   parameter int BLOCK_WORDS = 1026,
   parameter int WM_WORDS    = 4,
   parameter int SYNC_STAGES = 2,
   parameter int RDY_QUAL    = 2,
   parameter int CNT_W       = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              run,
   input  logic              mode_block,
   input  logic [ADDR_W-1:0] thread_sel,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] smp_data,
   input  logic              flag_ready,
   input  logic              flag_wm_n,
   output logic [DATA_W-1:0] bus_data,
   output logic              bus_wr,
   output logic              bus_pkt_end,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [CNT_W-1:0]  drop_count
);

   localparam int GW = $clog2(WM_WORDS + SYNC_STAGES + 2) + 1;

   generate
      if (SYNC_STAGES > WM_WORDS) begin : g_bad_budget
         $error("sfifo_stream_writer: flag latency exceeds watermark budget");
      end
   endgenerate

   logic rdy_s;
   logic wm_n_s;
   logic fifo_empty;
   logic fifo_drop;

   sfw_sync #(
      .W       (2),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (2'b00)
   ) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  ({flag_ready, flag_wm_n}),
      .dout ({rdy_s, wm_n_s})
   );

   sfw_fifo #(
      .DW    (DATA_W),
      .DEPTH (FIFO_DEPTH)
   ) u_fifo (
      .clk      (clk),
      .rst      (rst),
      .in_valid (smp_valid),
      .in_data  (smp_data),
      .pop      (bus_wr),
      .head     (bus_data),
      .empty    (fifo_empty),
      .drop     (fifo_drop)
   );

   sfw_ctrl #(
      .BLOCK_WORDS (BLOCK_WORDS),
      .RDY_QUAL    (RDY_QUAL),
      .ADDR_W      (ADDR_W)
   ) u_ctrl (
      .clk        (clk),
      .rst        (rst),
      .run        (run),
      .mode_block (mode_block),
      .thread_sel (thread_sel),
      .rdy_s      (rdy_s),
      .wm_n_s     (wm_n_s),
      .fifo_empty (fifo_empty),
      .wr_strobe  (bus_wr),
      .pkt_end    (bus_pkt_end),
      .bus_addr   (bus_addr)
   );

   sfw_drop_cnt #(
      .W (CNT_W)
   ) u_drop (
      .clk   (clk),
      .rst   (rst),
      .hit   (fifo_drop),
      .count (drop_count)
   );

   // writes seen since the raw watermark flag went low
   logic [GW-1:0] wm_gap;

   always_ff @(posedge clk) begin
      if (rst || flag_wm_n) begin
         wm_gap <= '0;
      end else if (bus_wr && (wm_gap != {GW{1'b1}})) begin
         wm_gap <= wm_gap + 1'b1;
      end
   end

   // R4: trailing writes after the watermark stay inside the budget
   a_r4_wm_budget: assert property (@(posedge clk) disable iff (rst)
      wm_gap <= GW'(WM_WORDS));

endmodule

// File: tb/sim_sfifo_stream_writer.sv
module sim_sfifo_stream_writer;

   localparam int DW    = 32;
   localparam int AW    = 2;
   localparam int DEPTH = 16;
   localparam int BLK   = 1026;
   localparam int WM    = 4;
   localparam int SYNC  = 2;
   localparam int CW    = 4;

   logic          clk = 1'b0;
   logic          rst;
   logic          run;
   logic          mode_block;
   logic [AW-1:0] thread_sel;
   logic          smp_valid;
   logic [DW-1:0] smp_data;
   logic          flag_ready;
   logic          flag_wm_n;
   logic [DW-1:0] bus_data;
   logic          bus_wr;
   logic          bus_pkt_end;
   logic [AW-1:0] bus_addr;
   logic [CW-1:0] drop_count;

   always #4 clk = ~clk;

   sfifo_stream_writer #(
      .DATA_W (DW), .ADDR_W (AW), .FIFO_DEPTH (DEPTH), .BLOCK_WORDS (BLK),
      .WM_WORDS (WM), .SYNC_STAGES (SYNC), .RDY_QUAL (2), .CNT_W (CW)
   ) u0 (
      .clk (clk), .rst (rst), .run (run), .mode_block (mode_block),
      .thread_sel (thread_sel), .smp_valid (smp_valid), .smp_data (smp_data),
      .flag_ready (flag_ready), .flag_wm_n (flag_wm_n), .bus_data (bus_data),
      .bus_wr (bus_wr), .bus_pkt_end (bus_pkt_end), .bus_addr (bus_addr),
      .drop_count (drop_count)
   );

   int checks = 0;
   int errors = 0;
   int seq    = 1;
   int exp_q[$];
   int exp_addr  = 0;
   int bidx      = 0;
   int pe_seen   = 0;
   int wm_gap    = 0;
   int wm_max    = 0;
   int wm_low    = 0;
   int late_bad  = 0;
   int run_bad   = 0;
   int cyc       = 0;
   bit done      = 1'b0;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic push_n(input int n, input bit keep);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         smp_valid = 1'b1;
         smp_data  = DW'(seq);
         if (keep) exp_q.push_back(seq);
         seq++;
      end
      @(posedge clk); #1;
      smp_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (!rst) begin
         if (flag_wm_n) begin
            wm_low = 0;
            wm_gap = 0;
         end else begin
            wm_low++;
         end
         if (bus_wr) begin
            if (exp_q.size() == 0) begin
               chk("R3 write with empty scoreboard", 1, 0);
            end else begin
               chk("R3 word order", int'(bus_data), exp_q.pop_front());
            end
            chk("R7 thread address", int'(bus_addr), exp_addr);
            if (mode_block) begin
               chk("R5 packet end position", int'(bus_pkt_end), (bidx == BLK - 1) ? 1 : 0);
               bidx = (bidx == BLK - 1) ? 0 : bidx + 1;
            end else begin
               chk("R6 packet end in continuous mode", int'(bus_pkt_end), 0);
            end
            if (!flag_wm_n) begin
               wm_gap++;
               if (wm_gap > wm_max) wm_max = wm_gap;
               if (wm_low > SYNC) late_bad++;
            end
            if (!run) run_bad++;
         end else if (bus_pkt_end) begin
            chk("R5 packet end without write", 1, 0);
         end
         if (bus_pkt_end) pe_seen++;
         if (!run || !mode_block) bidx = 0;
      end else begin
         bidx = 0;
      end
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc >= 100000 && !done) begin
         errors++;
         $display("FAIL watchdog R3 actual=%0d expected=%0d", cyc, 0);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; run = 1'b0; mode_block = 1'b0; thread_sel = '0;
      smp_valid = 1'b0; smp_data = '0; flag_ready = 1'b0; flag_wm_n = 1'b0;
      idle(4);
      @(negedge clk);
      chk("R1 reset write strobe", int'(bus_wr), 0);
      chk("R1 reset packet end", int'(bus_pkt_end), 0);
      chk("R1 reset address", int'(bus_addr), 0);
      chk("R1 reset drop count", int'(drop_count), 0);
      idle(1);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 first cycle after reset", int'(bus_wr), 0);

      // overflow with the bridge not ready
      idle(1);
      run = 1'b1; thread_sel = 2'd1; exp_addr = 1; flag_wm_n = 1'b1;
      push_n(DEPTH, 1'b1);
      push_n(5, 1'b0);
      @(negedge clk);
      chk("R8 drop count after 5 overflows", int'(drop_count), 5);
      push_n(12, 1'b0);
      @(negedge clk);
      chk("R9 drop count saturates", int'(drop_count), 15);
      chk("R8 held samples kept while not ready", exp_q.size(), DEPTH);

      // lone ready pulse must not start a burst
      idle(1);
      flag_ready = 1'b1;
      idle(1);
      flag_ready = 1'b0;
      idle(12);
      @(negedge clk);
      chk("R2 one-cycle ready pulse ignored", exp_q.size(), DEPTH);

      // steady ready drains the buffer in order
      idle(1);
      flag_ready = 1'b1;
      idle(40);
      @(negedge clk);
      chk("R3 buffer drained", exp_q.size(), 0);
      chk("R9 count holds at saturation", int'(drop_count), 15);

      idle(1);
      rst = 1'b1;
      idle(2);
      rst = 1'b0;
      @(negedge clk);
      chk("R9 reset clears drop count", int'(drop_count), 0);

      // block mode: two full blocks and a tail
      idle(1);
      mode_block = 1'b1; pe_seen = 0;
      push_n(2 * BLK + 10, 1'b1);
      idle(30);
      @(negedge clk);
      chk("R5 packet ends over two blocks", pe_seen, 2);
      chk("R3 block stream drained", exp_q.size(), 0);

      // continuous mode
      idle(1);
      mode_block = 1'b0; pe_seen = 0;
      push_n(1100, 1'b1);
      idle(30);
      @(negedge clk);
      chk("R6 no packet ends in continuous mode", pe_seen, 0);
      chk("R3 continuous stream drained", exp_q.size(), 0);

      // new burst on thread 2, thread_sel moves mid-burst
      idle(1);
      flag_wm_n = 1'b0;
      idle(6);
      thread_sel = 2'd2; exp_addr = 2;
      flag_wm_n = 1'b1;
      fork
         push_n(30, 1'b1);
         begin
            idle(10);
            thread_sel = 2'd3;
         end
      join
      idle(20);
      @(negedge clk);
      chk("R7 address held after mid-burst change", int'(bus_addr), 2);

      // watermark stop while streaming
      idle(1);
      wm_max = 0; late_bad = 0;
      fork
         push_n(30, 1'b1);
         begin
            idle(10);
            flag_wm_n = 1'b0;
            idle(8);
            exp_addr = 3;
            flag_wm_n = 1'b1;
         end
      join
      idle(30);
      @(negedge clk);
      checks++;
      if (wm_max > WM) begin
         errors++;
         $display("FAIL R4 writes after watermark actual=%0d expected<=%0d", wm_max, WM);
      end
      chk("R4 no write after flag latency", late_bad, 0);
      chk("R4 resumed and drained", exp_q.size(), 0);
      chk("R7 new burst captured thread 3", int'(bus_addr), 3);

      // run gating
      idle(1);
      run_bad = 0;
      fork
         push_n(30, 1'b1);
         begin
            idle(10);
            run = 1'b0;
            idle(5);
            run = 1'b1;
         end
      join
      idle(30);
      @(negedge clk);
      chk("R10 no write while run low", run_bad, 0);
      chk("R10 resumed and drained", exp_q.size(), 0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule